// File: doc/BRIEF.md
# Retriggerable One-Shot Pulse Timer

This block is a single down-counting timer channel that emits an active-low pulse of programmable length each time its trigger input rises. Software writes a pulse length N by placing it on a data bus together with a one-cycle load strobe. Writing the length only arms the channel. Nothing happens on the output until the trigger input shows a rising edge.

On the clock edge that follows a rising edge, the counter takes N and the output drops low. The output stays low for N clock cycles and then returns high. A further rising edge during a pulse restarts the full length from that edge. The same length can be fired any number of times without rewriting it.

A length written during a pulse is held back and takes effect only at the next trigger. The level of the trigger input never holds or forces the output.

Top module: `oneshot_timer`

## Requirements
- R1: While reset is asserted, and after it is released, `out_n` is 1 and the channel is unarmed.
- R2: Rising edges on `gate` before any count has been written since reset leave `out_n` at 1.
- R3: Writing a count (`load` = 1 for one cycle with the value on `din`) does not start a pulse by itself.
- R4: A rising edge on `gate` is a `gate` sample of 1 following a sample of 0. On an armed channel, `out_n` reads 0 after the clock edge that samples this edge. It stays 0 for exactly N cycles and then returns to 1.
- R5: A rising edge on `gate` during a pulse restarts it, so `out_n` stays 0 for N cycles counted from the latest edge.
- R6: Later rising edges fire new pulses with the stored count, without any new write.
- R7: A count written during a pulse does not alter that pulse. The next trigger uses the new count.
- R8: A steady `gate` level, high or low, and falling edges on `gate` do not change `out_n`.
- R9: A written count of 0 gives a pulse of 65536 cycles with the default 16-bit width.
- R10: If a write and a rising edge are sampled on the same clock edge, the pulse uses the count being written. This also applies to the first write after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| load | input | 1 | One-cycle strobe that writes `din` as the pulse length |
| din | input | CW | Pulse length N; 0 means 2^CW |
| gate | input | 1 | Trigger input; only its rising edge matters |
| out_n | output | 1 | Active-low one-shot pulse |

## Verification
The assertions assume that `gate` and `load` are synchronous to `clk` and hold steady around each rising edge. This allows an edge on `gate` to be judged from two consecutive clock samples. They also assume that reset is applied before the first trigger.

The stimulus changes every input only on the falling clock edge. Each `load` strobe is held for one cycle, and each `gate` level is held for at least one cycle, so every rising edge is sampled exactly once. The bench deliberately includes triggers that are unarmed, triggers that restart a pulse, a write that coincides with a trigger, and a long held-high `gate`.

// File: rtl/oneshot_timer.sv
module oneshot_timer #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] din,
  input  logic          gate,
  output logic          out_n
);

  logic [CW-1:0] len_q;
  logic [CW-1:0] cnt_q;
  logic          armed_q;
  logic          busy_q;
  logic          gate_q;

  logic          rise;
  logic          fire;
  logic [CW-1:0] len_now;

  assign rise    = gate & ~gate_q;
  assign fire    = rise & (armed_q | load);
  assign len_now = load ? din : len_q;
  assign out_n   = ~busy_q;

  always_ff @(posedge clk) gate_q <= gate;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q   <= '0;
      armed_q <= 1'b0;
    end else if (load) begin
      len_q   <= din;
      armed_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (fire) begin
      cnt_q  <= len_now;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == {{(CW-1){1'b0}}, 1'b1}) busy_q <= 1'b0;
    end
  end

endmodule

// File: rtl/oneshot_timer_chk.sv
module oneshot_timer_chk (
  input logic clk,
  input logic rst_n,
  input logic load,
  input logic gate,
  input logic out_n
);

  logic wr_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_seen <= 1'b0;
    else if (load) wr_seen <= 1'b1;
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk) !rst_n |-> out_n);

  // R2
  unarmed_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_seen |-> out_n);

  // R4
  pulse_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(gate) && (wr_seen || load)) |=> !out_n);

  // R8
  no_edge_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$rose(gate) && out_n) |=> out_n);

  // R3
  write_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !gate && out_n) |=> out_n);

endmodule

bind oneshot_timer oneshot_timer_chk u_chk (
  .clk  (clk),
  .rst_n(rst_n),
  .load (load),
  .gate (gate),
  .out_n(out_n)
);

// File: tb/sim_oneshot_timer.sv
module sim_oneshot_timer;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          load = 1'b0;
  logic [CW-1:0] din = '0;
  logic          gate = 1'b0;
  logic          out_n;

  int    checks = 0;
  int    errors = 0;
  int    cycles = 0;
  string req = "R1";

  // reference model state
  int rem = 0;
  int stored = 0;
  bit armed = 0;
  bit gprev = 0;

  always #2 clk = ~clk;

  oneshot_timer #(.CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .load(load), .din(din), .gate(gate), .out_n(out_n)
  );

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      rem = 0; stored = 0; armed = 0;
    end else begin
      bit trig;
      int nn;
      trig = gate && !gprev && (armed || load);
      nn   = load ? ((din == 0) ? (1 << CW) : int'(din)) : stored;
      if (load) begin
        stored = (din == 0) ? (1 << CW) : int'(din);
        armed  = 1;
      end
      if (trig) rem = nn;
      else if (rem > 0) rem--;
    end
    gprev = gate;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      bit exp_o;
      exp_o = (rem == 0);
      checks++;
      if (out_n !== exp_o) begin
        errors++;
        $display("FAIL %s: cycle %0d out_n=%b expected %b", req, cycles, out_n, exp_o);
      end
    end
  end

  always @(negedge clk) begin
    if (cycles > 190000) begin
      errors++;
      $display("FAIL watchdog: run did not finish, out_n=%b expected completion", out_n);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int v);
    @(negedge clk); load = 1'b1; din = CW'(v);
    @(negedge clk); load = 1'b0;
  endtask

  task automatic pulse_gate(input int hi, input int lo);
    @(negedge clk); gate = 1'b1;
    tick(hi);
    gate = 1'b0;
    tick(lo);
  endtask

  initial begin
    tick(3);
    // R1: reset state
    checks++;
    if (out_n !== 1'b1) begin
      errors++;
      $display("FAIL R1: out_n=%b expected 1 during reset", out_n);
    end
    rst_n = 1'b1;
    tick(3);
    req = "R2"; pulse_gate(3, 3); pulse_gate(1, 4);
    req = "R3"; wr(5); tick(8);
    req = "R4"; pulse_gate(2, 10);
    req = "R6"; pulse_gate(1, 10); pulse_gate(4, 8);
    req = "R5"; pulse_gate(1, 2); pulse_gate(1, 1); pulse_gate(1, 10);
    req = "R7"; @(negedge clk); gate = 1'b1; tick(1); gate = 1'b0;
    wr(3); tick(8);
    pulse_gate(1, 8);
    req = "R8"; @(negedge clk); gate = 1'b1; tick(20); gate = 1'b0; tick(10);
    req = "R10"; @(negedge clk); gate = 1'b1; load = 1'b1; din = CW'(7);
    @(negedge clk); load = 1'b0; tick(2); gate = 1'b0; tick(10);
    req = "R4"; wr(1); pulse_gate(1, 4); pulse_gate(3, 4);
    req = "R9"; wr(0); pulse_gate(1, 65540);
    req = "R6"; wr(2); pulse_gate(1, 5);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule